// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the target (slave) side of a two-wire I2C link with a small register port. It synchronizes the incoming clock and data lines through a flop chain. It detects start and stop conditions and shifts in the address byte. When the seven address bits equal the programmed own address, it acknowledges. After that it either captures a byte written by the external controller or supplies a byte for the controller to read. The open-drain pads are modelled as two output enables. An enable bit high means the block pulls that wire low.

Each data byte is handed to software, and the engine holds the clock line low until software has serviced the data register. For a received byte, software reads the register, and only then is the byte acknowledged and the clock released. For a transmit slot, software writes the register, and only then is the first bit presented and the clock released. Three interrupt sources have raw, mask and clear registers and are combined onto one interrupt output: a data event, a start condition and a stop condition.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, every register reads 0 and neither pad enable is asserted. The register offsets are: 0 own address, 1 status on read and control on write, 2 data, 3 mask, 4 raw events, 5 masked events, 6 clear. The interrupt output is low after reset.
- R2: While the enable (control bit 0, written at offset 1) is 0, the block does not acknowledge, does not stretch, and records no interrupt events.
- R3: While enabled, a start (SDA falling while SCL is high) sets raw bit 1, and a stop (SDA rising while SCL is high) sets raw bit 2.
- R4: The address byte is received MSB first as a6..a0 followed by a direction bit, where 1 means read. It is acknowledged (SDA driven low during the ninth clock) only when a6..a0 equal own-address bits 6:0. On a mismatch, the block leaves the bus alone until the next start, and later bytes get no acknowledge.
- R5: In a write transfer, each received byte is placed in the data register and status bit 0 (receive pending) is set. SCL is held low until software reads the data register, and the byte is then acknowledged.
- R6: Status bit 2 (first byte) is set only with the first byte after the address of a write transfer. It clears when the data register is read and stays 0 for later bytes and for all read transfers.
- R7: In a read transfer, status bit 1 (transmit pending) is set after the address acknowledge and after every byte the controller acknowledges. SCL is held low until software writes the data register, and the written byte is then sent MSB first.
- R8: When the controller does not acknowledge a transmitted byte, the block releases SDA and does not stretch or drive until a stop or a repeated start. A repeated start is then handled normally.
- R9: Raw bit 0 is set whenever a receive or transmit pending state is entered. The masked register (offset 5) equals raw AND mask, and the interrupt output is high whenever any masked bit is set.
- R10: Writing 1 to a bit of the clear register clears that raw bit and its masked copy. Bits written 0 are left unchanged.
- R11: A data-register write while no transfer is pending is held and read back unchanged. The own address reads back as written.
- R12: SDA enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Clock line as seen at the pad |
| sda_i | input | 1 | Data line as seen at the pad |
| scl_oe | output | 1 | Pull clock line low (stretch) |
| sda_oe | output | 1 | Pull data line low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | OR of masked interrupt bits |

## Verification
The bench builds the block with its default two-stage synchronizer and the fixed eight-bit data path. It models the external controller as a wired-AND line driver that waits while SCL is stretched. That size brings all 128 possible addresses into one sweep, so acknowledge-only-on-match is checked for every value. It also brings all eight mask patterns within reach, so masked status and the interrupt output are checked against every mask against a full raw set. It then runs multi-byte write and read transfers with mixed byte patterns. Those transfers cover the stretch windows, the first-byte flag, a controller NACK and recovery through a repeated start.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int REG_AW  = 3;
    localparam int NUM_EV  = 3;

    localparam int EV_DATA  = 0;
    localparam int EV_START = 1;
    localparam int EV_STOP  = 2;

    localparam logic [REG_AW-1:0] RG_OWN    = 3'd0;
    localparam logic [REG_AW-1:0] RG_STAT   = 3'd1;
    localparam logic [REG_AW-1:0] RG_DATA   = 3'd2;
    localparam logic [REG_AW-1:0] RG_MASK   = 3'd3;
    localparam logic [REG_AW-1:0] RG_RAW    = 3'd4;
    localparam logic [REG_AW-1:0] RG_MASKED = 3'd5;
    localparam logic [REG_AW-1:0] RG_CLR    = 3'd6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ADDR_ACK,
        ST_RX_BITS,
        ST_RX_END,
        ST_RX_WAIT,
        ST_RX_ACKH,
        ST_RX_ACK,
        ST_TX_WAIT,
        ST_TX_HOLD,
        ST_TX_BITS,
        ST_TX_ACK,
        ST_TX_ACKD,
        ST_IGNORE
    } eng_state_e;

    typedef struct packed {
        eng_state_e          state;
        logic [DATA_W-1:0]   sh;
        logic [CNT_W-1:0]    cnt;
        logic                first;
        logic                fbr;
        logic                scl_p;
        logic                sda_p;
        logic                rx_vld;
        logic [NUM_EV-1:0]   ev;
    } eng_t;

    typedef struct packed {
        logic [ADDR_W-1:0]   own;
        logic                en;
        logic [DATA_W-1:0]   data;
        logic [NUM_EV-1:0]   mask;
        logic [NUM_EV-1:0]   raw;
    } regs_t;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], d[g]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign q[g] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_s,
    input  logic                sda_s,
    input  logic                en,
    input  logic [ADDR_W-1:0]   own_addr,
    input  logic                tx_wr,
    input  logic [DATA_W-1:0]   tx_byte,
    input  logic                rx_rd,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic                rx_vld,
    output logic [DATA_W-1:0]   rx_byte,
    output logic [NUM_EV-1:0]   ev,
    output logic                treq,
    output logic                rreq,
    output logic                fbr
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    eng_t e_d, e_q;

    logic rise, fall, start_c, stop_c;

    always_comb begin
        rise    = scl_s & ~e_q.scl_p;
        fall    = ~scl_s & e_q.scl_p;
        start_c = e_q.scl_p & scl_s & e_q.sda_p & ~sda_s;
        stop_c  = e_q.scl_p & scl_s & ~e_q.sda_p & sda_s;

        e_d        = e_q;
        e_d.scl_p  = scl_s;
        e_d.sda_p  = sda_s;
        e_d.rx_vld = 1'b0;
        e_d.ev     = '0;

        if (!en) begin
            e_d.state = ST_IDLE;
            e_d.fbr   = 1'b0;
        end else if (start_c) begin
            e_d.ev[EV_START] = 1'b1;
            e_d.state        = ST_ADDR;
            e_d.cnt          = '0;
            e_d.fbr          = 1'b0;
        end else if (stop_c) begin
            e_d.ev[EV_STOP] = 1'b1;
            e_d.state       = ST_IDLE;
            e_d.fbr         = 1'b0;
        end else begin
            unique case (e_q.state)
                ST_ADDR: if (rise) begin
                    e_d.sh  = {e_q.sh[DATA_W-2:0], sda_s};
                    e_d.cnt = e_q.cnt + 1'b1;
                    if (e_q.cnt == LAST_BIT) e_d.state = ST_ADDR_END;
                end
                ST_ADDR_END: if (fall) begin
                    if (e_q.sh[DATA_W-1:1] == own_addr) e_d.state = ST_ADDR_ACK;
                    else                                e_d.state = ST_IGNORE;
                end
                ST_ADDR_ACK: if (fall) begin
                    if (e_q.sh[0]) begin
                        e_d.state       = ST_TX_WAIT;
                        e_d.ev[EV_DATA] = 1'b1;
                    end else begin
                        e_d.state = ST_RX_BITS;
                        e_d.cnt   = '0;
                        e_d.first = 1'b1;
                    end
                end
                ST_RX_BITS: if (rise) begin
                    e_d.sh  = {e_q.sh[DATA_W-2:0], sda_s};
                    e_d.cnt = e_q.cnt + 1'b1;
                    if (e_q.cnt == LAST_BIT) e_d.state = ST_RX_END;
                end
                ST_RX_END: if (fall) begin
                    e_d.rx_vld      = 1'b1;
                    e_d.fbr         = e_q.first;
                    e_d.first       = 1'b0;
                    e_d.ev[EV_DATA] = 1'b1;
                    e_d.state       = ST_RX_WAIT;
                end
                ST_RX_WAIT: if (rx_rd) begin
                    e_d.fbr   = 1'b0;
                    e_d.state = ST_RX_ACKH;
                end
                ST_RX_ACKH: e_d.state = ST_RX_ACK;
                ST_RX_ACK: if (fall) begin
                    e_d.state = ST_RX_BITS;
                    e_d.cnt   = '0;
                end
                ST_TX_WAIT: if (tx_wr) begin
                    e_d.sh    = tx_byte;
                    e_d.cnt   = '0;
                    e_d.state = ST_TX_HOLD;
                end
                ST_TX_HOLD: e_d.state = ST_TX_BITS;
                ST_TX_BITS: if (fall) begin
                    if (e_q.cnt == LAST_BIT) begin
                        e_d.state = ST_TX_ACK;
                    end else begin
                        e_d.sh  = {e_q.sh[DATA_W-2:0], 1'b0};
                        e_d.cnt = e_q.cnt + 1'b1;
                    end
                end
                ST_TX_ACK: if (rise) begin
                    if (!sda_s) e_d.state = ST_TX_ACKD;
                    else        e_d.state = ST_IGNORE;
                end
                ST_TX_ACKD: if (fall) begin
                    e_d.state       = ST_TX_WAIT;
                    e_d.ev[EV_DATA] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q       <= '0;
            e_q.state <= ST_IDLE;
            e_q.scl_p <= 1'b1;
            e_q.sda_p <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    always_comb begin
        scl_oe = (e_q.state == ST_RX_WAIT) || (e_q.state == ST_RX_ACKH) ||
                 (e_q.state == ST_TX_WAIT) || (e_q.state == ST_TX_HOLD);
        sda_oe = (e_q.state == ST_ADDR_ACK) || (e_q.state == ST_RX_ACKH) ||
                 (e_q.state == ST_RX_ACK) ||
                 (((e_q.state == ST_TX_HOLD) || (e_q.state == ST_TX_BITS)) &&
                  !e_q.sh[DATA_W-1]);
        treq    = (e_q.state == ST_TX_WAIT);
        rreq    = (e_q.state == ST_RX_WAIT);
        fbr     = e_q.fbr;
        rx_vld  = e_q.rx_vld;
        rx_byte = e_q.sh;
        ev      = e_q.ev;
    end

endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
    import i2ct_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic [REG_AW-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                rx_vld,
    input  logic [DATA_W-1:0]   rx_byte,
    input  logic [NUM_EV-1:0]   ev,
    input  logic                treq,
    input  logic                rreq,
    input  logic                fbr,
    output logic [ADDR_W-1:0]   own,
    output logic                en,
    output logic                tx_wr,
    output logic                rx_rd,
    output logic [NUM_EV-1:0]   raw,
    output logic [NUM_EV-1:0]   clr,
    output logic                irq
);

    regs_t r_d, r_q;

    always_comb begin
        tx_wr = wr && (addr == RG_DATA);
        rx_rd = rd && (addr == RG_DATA);
        clr   = (wr && (addr == RG_CLR)) ? wdata[NUM_EV-1:0] : '0;

        r_d = r_q;
        if (wr && (addr == RG_OWN))  r_d.own  = wdata[ADDR_W-1:0];
        if (wr && (addr == RG_STAT)) r_d.en   = wdata[0];
        if (wr && (addr == RG_MASK)) r_d.mask = wdata[NUM_EV-1:0];
        if (rx_vld)      r_d.data = rx_byte;
        else if (tx_wr)  r_d.data = wdata;
        r_d.raw = (r_q.raw & ~clr) | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (addr)
            RG_OWN:    rdata = DATA_W'(r_q.own);
            RG_STAT:   rdata = DATA_W'({fbr, treq, rreq});
            RG_DATA:   rdata = r_q.data;
            RG_MASK:   rdata = DATA_W'(r_q.mask);
            RG_RAW:    rdata = DATA_W'(r_q.raw);
            RG_MASKED: rdata = DATA_W'(r_q.raw & r_q.mask);
            default:   rdata = '0;
        endcase
        own = r_q.own;
        en  = r_q.en;
        raw = r_q.raw;
        irq = |(r_q.raw & r_q.mask);
    end

endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                scl_oe,
    output logic                sda_oe,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq
);

    logic [1:0]          line_s;
    logic                en_w, tx_wr_w, rx_rd_w, rx_vld_w;
    logic                treq_w, rreq_w, fbr_w;
    logic [DATA_W-1:0]   rx_byte_w;
    logic [ADDR_W-1:0]   own_w;
    logic [NUM_EV-1:0]   ev_w, raw_w, clr_w;

    i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sda_i, scl_i}),
        .q     (line_s)
    );

    i2ct_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (line_s[0]),
        .sda_s    (line_s[1]),
        .en       (en_w),
        .own_addr (own_w),
        .tx_wr    (tx_wr_w),
        .tx_byte  (reg_wdata),
        .rx_rd    (rx_rd_w),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .rx_vld   (rx_vld_w),
        .rx_byte  (rx_byte_w),
        .ev       (ev_w),
        .treq     (treq_w),
        .rreq     (rreq_w),
        .fbr      (fbr_w)
    );

    i2ct_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .rx_vld  (rx_vld_w),
        .rx_byte (rx_byte_w),
        .ev      (ev_w),
        .treq    (treq_w),
        .rreq    (rreq_w),
        .fbr     (fbr_w),
        .own     (own_w),
        .en      (en_w),
        .tx_wr   (tx_wr_w),
        .rx_rd   (rx_rd_w),
        .raw     (raw_w),
        .clr     (clr_w),
        .irq     (irq)
    );

endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk
    import i2ct_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              en,
    input logic              treq,
    input logic              rreq,
    input logic              fbr,
    input logic              rx_rd,
    input logic [NUM_EV-1:0] ev,
    input logic [NUM_EV-1:0] raw,
    input logic [NUM_EV-1:0] clr
);

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (!scl_oe && !sda_oe));

    // R12
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (sda_oe != $past(sda_oe))) |-> (!scl_i && !$past(scl_i)));

    // R6
    fbr_with_rreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fbr |-> rreq);

    // R5
    rreq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rreq) && !$past(rx_rd) && $past(en) && en) |-> (rreq && scl_oe));

    // R7
    treq_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        treq |-> (scl_oe && !sda_oe));

    // R10
    clear_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr[EV_DATA]) && !$past(ev[EV_DATA])) |-> !raw[EV_DATA]);

endmodule

bind i2c_target_stretch i2ct_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .en     (en_w),
    .treq   (treq_w),
    .rreq   (rreq_w),
    .fbr    (fbr_w),
    .rx_rd  (rx_rd_w),
    .ev     (ev_w),
    .raw    (raw_w),
    .clr    (clr_w)
);

// File: tb/i2c_target_stretch_test.sv
module i2c_target_stretch_test;

    localparam int Q   = 8;
    localparam logic [6:0] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_scl = 1'b1, ctrl_sda = 1'b1;
    logic       scl_i, sda_i, scl_oe, sda_oe;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign scl_i = ctrl_scl & ~scl_oe;
    assign sda_i = ctrl_sda & ~sda_oe;

    i2c_target_stretch uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_high();
        int k;
        k = 0;
        while (!scl_i && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (!scl_i) chk("R5/R7 clock release timeout", 0, 1);
    endtask

    task automatic bus_start();
        ctrl_sda = 1'b1; ctrl_scl = 1'b1; wq();
        ctrl_sda = 1'b0; wq();
        ctrl_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        ctrl_sda = 1'b0; wq();
        ctrl_scl = 1'b1; wait_high(); wq();
        ctrl_sda = 1'b1; wq();
    endtask

    task automatic bus_restart();
        ctrl_sda = 1'b1; wq();
        ctrl_scl = 1'b1; wait_high(); wq();
        ctrl_sda = 1'b0; wq();
        ctrl_scl = 1'b0; wq();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        ctrl_sda = b; wq();
        ctrl_scl = 1'b1; wait_high(); wq();
        s = sda_i;
        ctrl_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, b;
        logic s;
        logic [7:0] wpat [4];
        logic [7:0] rpat [3];
        wpat[0] = 8'hA5; wpat[1] = 8'h5A; wpat[2] = 8'h00; wpat[3] = 8'hFF;
        rpat[0] = 8'hC3; rpat[1] = 8'h81; rpat[2] = 8'h7E;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 7; a++) begin
            reg_read(3'(a), v);
            chk($sformatf("R1 reset reg %0d", a), v, 0);
        end
        chk("R1 scl_oe at reset", scl_oe, 0);
        chk("R1 sda_oe at reset", sda_oe, 0);
        chk("R1 irq at reset", irq, 0);

        // R11 own address readback, R2 disabled bus is ignored
        reg_write(3'd0, {1'b0, OWN});
        reg_read(3'd0, v);
        chk("R11 own address readback", v, OWN);
        bus_start();
        send_byte({OWN, 1'b0});
        clk_bit(1'b1, s);
        chk("R2 no ack while disabled", s, 1);
        bus_stop();
        reg_read(3'd4, v);
        chk("R2 no events while disabled", v, 0);

        // R11 control write at shared offset
        reg_write(3'd1, 8'h01);
        reg_read(3'd1, v);
        chk("R11 status after enable", v, 0);

        // R4 address sweep
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0});
            clk_bit(1'b1, s);
            chk($sformatf("R4 ack for addr %02h", a), s, (7'(a) == OWN) ? 0 : 1);
            if (7'(a) != OWN && (a % 8) == 3) begin
                send_byte(8'h00);
                clk_bit(1'b1, s);
                chk($sformatf("R4 ignored after mismatch %02h", a), s, 1);
            end
            bus_stop();
        end
        reg_read(3'd4, v);
        chk("R3 start and stop raw bits", v, 3'b110);
        reg_write(3'd6, 8'h07);
        reg_read(3'd4, v);
        chk("R10 full clear", v, 0);

        // R5/R6 write transfer
        bus_start();
        send_byte({OWN, 1'b0});
        clk_bit(1'b1, s);
        chk("R4 write address ack", s, 0);
        for (int i = 0; i < 4; i++) begin
            send_byte(wpat[i]);
            ctrl_sda = 1'b1; ctrl_scl = 1'b1;
            repeat (40) @(negedge clk);
            chk($sformatf("R5 clock held byte %0d", i), scl_i, 0);
            reg_read(3'd1, v);
            chk($sformatf("R5 R6 status pending byte %0d", i), v, (i == 0) ? 3'b101 : 3'b001);
            reg_read(3'd4, v);
            chk($sformatf("R9 data event byte %0d", i), v[0], 1);
            reg_write(3'd6, 8'h01);
            reg_read(3'd2, v);
            chk($sformatf("R5 received byte %0d", i), v, wpat[i]);
            reg_read(3'd1, v);
            chk($sformatf("R6 status cleared byte %0d", i), v, 0);
            wait_high(); wq();
            chk($sformatf("R5 data ack byte %0d", i), sda_i, 0);
            ctrl_scl = 1'b0; wq();
        end
        bus_stop();

        // R7/R8 read transfer
        bus_start();
        send_byte({OWN, 1'b1});
        clk_bit(1'b1, s);
        chk("R4 read address ack", s, 0);
        for (int i = 0; i < 3; i++) begin
            reg_read(3'd1, v);
            chk($sformatf("R7 R6 tx pending byte %0d", i), v, 3'b010);
            reg_read(3'd4, v);
            chk($sformatf("R9 tx data event byte %0d", i), v[0], 1);
            ctrl_sda = 1'b1; ctrl_scl = 1'b1;
            repeat (40) @(negedge clk);
            chk($sformatf("R7 clock held byte %0d", i), scl_i, 0);
            reg_write(3'd2, rpat[i]);
            wait_high(); wq();
            b[7] = sda_i;
            ctrl_scl = 1'b0; wq();
            for (int k = 6; k >= 0; k--) begin
                clk_bit(1'b1, s);
                b[k] = s;
            end
            chk($sformatf("R7 sent byte %0d", i), b, rpat[i]);
            clk_bit((i == 2) ? 1'b1 : 1'b0, s);
        end
        reg_read(3'd1, v);
        chk("R8 no pending after nack", v, 0);
        recv_byte(b);
        chk("R8 line released after nack", b, 8'hFF);
        chk("R8 no stretch after nack", scl_oe, 0);
        bus_restart();
        send_byte({OWN, 1'b0});
        clk_bit(1'b1, s);
        chk("R8 ack after repeated start", s, 0);
        bus_stop();

        // R11 data write held while idle
        reg_write(3'd2, 8'h77);
        reg_read(3'd2, v);
        chk("R11 data hold", v, 8'h77);

        // R9 mask sweep over full raw set
        reg_read(3'd4, v);
        chk("R9 raw all set", v, 3'b111);
        for (int m = 0; m < 8; m++) begin
            reg_write(3'd3, 8'(m));
            reg_read(3'd5, v);
            chk($sformatf("R9 masked for mask %0d", m), v, m);
            chk($sformatf("R9 irq for mask %0d", m), irq, (m != 0) ? 1 : 0);
        end

        // R10 selective clear
        reg_write(3'd6, 8'h00);
        reg_read(3'd4, v);
        chk("R10 clear of zero", v, 3'b111);
        for (int k = 0; k < 3; k++) begin
            reg_write(3'd6, 8'(1 << k));
            reg_read(3'd4, v);
            chk($sformatf("R10 raw after clear bit %0d", k), v, 3'b111 & ~((2 << k) - 1));
            reg_read(3'd5, v);
            chk($sformatf("R10 masked after clear bit %0d", k), v, 3'b111 & ~((2 << k) - 1));
        end
        chk("R9 irq low when cleared", irq, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule